// File: doc/BRIEF.md
# Transmit Interrupt Handshake Sequencer

This block runs the host interrupt handshake for transmit service in a two-channel serial controller. Either channel can raise a transmit-service request. The sequencer accepts the request and records which channel raised it. It then waits for a fairness arbiter to grant permission before it drives the interrupt line to the host. When the host runs its interrupt-acknowledge cycle, the block returns an 8-bit vector. The upper six bits of that vector come from a programmable base register, and the lower two bits are fixed and mark the interrupt as a transmit interrupt. The host closes the handshake by writing the end-of-interrupt register.

The host can read a byte-wide status register at any time. It shows three phase flags (enable, active and end-of-interrupt), the fixed vector bits and the number of the channel being served. The block supports two bus address maps, selected by a static input. The second map moves every register by clearing address bit 1.

Top module: `tx_irq_seq`

## Requirements
- R1: After reset the phase flags are 000, `irq_o` is low, the captured channel is 0 and the vector base reads back as 0.
- R2: A request on `req_i` is accepted only in the idle (000) or completed (001) phase. On acceptance the flags become 100, the end-of-interrupt flag clears, and the channel is captured, with channel 0 winning when both channels request.
- R3: In phase 100 with `grant_i` high, the next phase is 110. `irq_o` is high in phase 110 and in no other phase.
- R4: `iack_i` in phase 110 moves the block to phase 010. In that same cycle `vec_o` equals {base[5:0], 2'b10}. At all other times `vec_o` is 0, and `iack_i` outside phase 110 leaves the phase unchanged.
- R5: An end-of-interrupt write in phase 010 moves the block to phase 001. In any other phase the write is ignored.
- R6: The status byte is {enable, active, eoi, 1'b0, 2'b10, 1'b0, channel}: enable at bit 7, active at bit 6, eoi at bit 5, the vector bits at 3:2 and the channel at bit 0. Bits 4 and 1 always read 0.
- R7: With `map_i`=0 the registers sit at status 0xEE, end-of-interrupt 0xEA and vector base 0xE2. With `map_i`=1 they sit at 0xEC, 0xE8 and 0xE0. Every other address reads 0.
- R8: The captured channel holds from one acceptance to the next. Requests in phases 100, 110 and 010 are ignored.
- R9: A write to the vector-base address stores `wdata_i[7:2]`. A read of that address returns {base, 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Transmit-service request, one bit per channel |
| grant_i | input | 1 | Fairness permission to assert the interrupt |
| iack_i | input | 1 | Host interrupt-acknowledge cycle |
| map_i | input | 1 | Address map select |
| addr_i | input | 8 | Host register address |
| wr_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Host read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request to the host |
| vec_o | output | 8 | Vector driven during the acknowledge cycle |

## Verification
Two collisions are driven on purpose.

- **Acknowledge and end-of-interrupt write together.** While the interrupt is asserted, the bench drives an acknowledge, an end-of-interrupt write and requests from both channels in the same cycle. The expected result is that the acknowledge alone takes effect: the phase goes to 010, the vector appears and the channel does not move.
- **End-of-interrupt write with new requests.** In phase 010 the bench pairs the end-of-interrupt write with requests. The phase must reach 001 without picking up the request. A following request from the other channel must then be accepted and must clear the end-of-interrupt flag.

Each case is judged from the status byte read back at the ports.

// File: rtl/tx_irq_pkg.sv
package tx_irq_pkg;
  // state encoding is the visible {enable, active, eoi} triple
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_REQ  = 3'b100,
    ST_ASRT = 3'b110,
    ST_ACK  = 3'b010,
    ST_DONE = 3'b001
  } hs_state_e;

  localparam logic [1:0] TX_VEC_LOW = 2'b10;
endpackage

// File: rtl/tx_irq_fsm.sv
module tx_irq_fsm
  import tx_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              grant_i,
  input  logic              iack_i,
  input  logic              eoi_wr_i,
  output hs_state_e         state_o,
  output logic [CH_W-1:0]   ch_o
);
  hs_state_e       state_q, state_d;
  logic [CH_W-1:0] ch_q, ch_d, pick;
  logic            open_slot, accept;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) pick = CH_W'(i);
    end
  end

  assign open_slot = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign accept    = open_slot && (|req_i);

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (accept) begin
        state_d = ST_REQ;
        ch_d    = pick;
      end
      ST_REQ:  if (grant_i)  state_d = ST_ASRT;
      ST_ASRT: if (iack_i)   state_d = ST_ACK;
      ST_ACK:  if (eoi_wr_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
    end
  end

  assign state_o = state_q;
  assign ch_o    = ch_q;

  AST_GRANT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && grant_i) |=> (state_q == ST_ASRT)); // R3
  AST_IACK_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASRT && iack_i) |=> (state_q == ST_ACK)); // R4
  AST_EOI_EARLY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && !grant_i && eoi_wr_i) |=> (state_q == ST_REQ)); // R5
  AST_CH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_REQ, ST_ASRT, ST_ACK}) |=> $stable(ch_q)); // R8
  AST_REQ_CLEARS_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && (|req_i)) |=> (state_q == ST_REQ)); // R2
endmodule

// File: rtl/tx_irq_regs.sv
module tx_irq_regs #(
  parameter int             ADDR_W     = 8,
  parameter int             DATA_W     = 8,
  parameter int             VB_W       = DATA_W - 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'hEE,
  parameter logic [ADDR_W-1:0] EOI_ADDR   = 8'hEA,
  parameter logic [ADDR_W-1:0] VBASE_ADDR = 8'hE2,
  parameter logic [ADDR_W-1:0] ALT_FLIP   = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              eoi_wr_o,
  output logic [VB_W-1:0]   vbase_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LOW_W = DATA_W - VB_W;

  logic [ADDR_W-1:0] a_stat, a_eoi, a_vb;
  logic              hit_stat, hit_eoi, hit_vb;
  logic [VB_W-1:0]   vbase_q;

  // second map clears the flip bits of every address
  assign a_stat = map_i ? (STAT_ADDR  & ~ALT_FLIP) : STAT_ADDR;
  assign a_eoi  = map_i ? (EOI_ADDR   & ~ALT_FLIP) : EOI_ADDR;
  assign a_vb   = map_i ? (VBASE_ADDR & ~ALT_FLIP) : VBASE_ADDR;

  assign hit_stat = (addr_i == a_stat);
  assign hit_eoi  = (addr_i == a_eoi);
  assign hit_vb   = (addr_i == a_vb);

  assign eoi_wr_o = wr_i && hit_eoi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             vbase_q <= '0;
    else if (wr_i && hit_vb) vbase_q <= wdata_i[DATA_W-1:LOW_W];
  end

  assign vbase_o = vbase_q;

  always_comb begin
    rd_data_o = '0;
    if (hit_stat)    rd_data_o = status_i;
    else if (hit_vb) rd_data_o = {vbase_q, {LOW_W{1'b0}}};
  end

  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit_vb) |=> $stable(vbase_q)); // R9
  AST_EOI_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr_o |-> (wr_i && !hit_stat && !hit_vb)); // R7
endmodule

// File: rtl/tx_irq_vec.sv
module tx_irq_vec
  import tx_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int VB_W   = DATA_W - 2,
  parameter int CH_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hs_state_e         state_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              iack_i,
  input  logic [VB_W-1:0]   vbase_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] vec_o,
  output logic [DATA_W-1:0] status_o
);
  logic asserted;

  assign asserted = (state_i == ST_ASRT);
  assign irq_o    = asserted;
  assign vec_o    = (iack_i && asserted) ? {vbase_i, TX_VEC_LOW} : '0;

  // {en, act, eoi, 0, vec[1:0], 0, ch}
  assign status_o = {state_i, 1'b0, TX_VEC_LOW, 1'b0, ch_i[0]};

  AST_IRQ_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(state_i) == ST_REQ)); // R3
  AST_VEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o || !iack_i) |-> (vec_o == '0)); // R4
  AST_IRQ_DROPS_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && iack_i) |=> !irq_o); // R4
endmodule

// File: rtl/tx_irq_seq.sv
module tx_irq_seq
  import tx_irq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              grant_i,
  input  logic              iack_i,
  input  logic              map_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int VB_W = DATA_W - 2;

  hs_state_e         state;
  logic [CH_W-1:0]   ch;
  logic              eoi_wr;
  logic [VB_W-1:0]   vbase;
  logic [DATA_W-1:0] status;

  tx_irq_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
    .clk_i, .rst_ni, .req_i, .grant_i, .iack_i,
    .eoi_wr_i(eoi_wr), .state_o(state), .ch_o(ch)
  );

  tx_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VB_W(VB_W)) u_regs (
    .clk_i, .rst_ni, .map_i, .addr_i, .wr_i, .wdata_i,
    .status_i(status), .eoi_wr_o(eoi_wr), .vbase_o(vbase), .rd_data_o
  );

  tx_irq_vec #(.DATA_W(DATA_W), .VB_W(VB_W), .CH_W(CH_W)) u_vec (
    .clk_i, .rst_ni, .state_i(state), .ch_i(ch), .iack_i,
    .vbase_i(vbase), .irq_o, .vec_o, .status_o(status)
  );
endmodule

// File: tb/sim_tx_irq_seq.sv
`timescale 1ns/1ps
module sim_tx_irq_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req = '0;
  logic       grant = 1'b0, iack = 1'b0, map_sel = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rd_data, vec;
  logic       irq;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [2:0] ef;
  logic       ech;

  always #4 clk = ~clk;

  tx_irq_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .grant_i(grant), .iack_i(iack),
    .map_i(map_sel), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_data_o(rd_data), .irq_o(irq), .vec_o(vec)
  );

  function automatic logic [7:0] a_stat(input logic m); return m ? 8'hEC : 8'hEE; endfunction
  function automatic logic [7:0] a_eoi (input logic m); return m ? 8'hE8 : 8'hEA; endfunction
  function automatic logic [7:0] a_vb  (input logic m); return m ? 8'hE0 : 8'hE2; endfunction
  function automatic logic [7:0] exp_stat(); return {ef, 1'b0, 2'b10, 1'b0, ech}; endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    req = '0; grant = 0; iack = 0; wr = 0; wdata = '0;
  endtask

  task automatic see_stat(input string tag);
    addr = a_stat(map_sel);
    #1;
    chk(tag, rd_data, exp_stat());
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, ef == 3'b110});
  endtask

  task automatic run_pass(input logic [1:0] pat, input logic [5:0] b);
    // R9 base write, low bits ignored
    addr = a_vb(map_sel); wr = 1; wdata = {b, 2'b11};
    tick(); quiet(); #1;
    chk("R9 base readback", rd_data, {b, 2'b00});
    // R5 EOI and R4 iack ignored in idle/done
    addr = a_eoi(map_sel); wr = 1; iack = 1; #1;
    chk("R4 vec zero outside assert", vec, 8'h00);
    tick(); quiet();
    see_stat("R5 eoi ignored idle/done");
    // R2 accept with priority
    req = pat; tick(); quiet();
    ef = 3'b100; ech = pat[0] ? 1'b0 : 1'b1;
    see_stat("R2 accept");
    // R8 requests, R5 eoi and R4 iack ignored while waiting for grant
    req = 2'b11; iack = 1; addr = a_eoi(map_sel); wr = 1; #1;
    chk("R4 vec zero in 100", vec, 8'h00);
    tick(); quiet();
    see_stat("R8 hold in 100");
    // R3 grant
    grant = 1; tick(); quiet();
    ef = 3'b110;
    see_stat("R3 asserted");
    // R4 ack with colliding EOI write and requests
    iack = 1; req = 2'b11; addr = a_eoi(map_sel); wr = 1; #1;
    chk("R4 vector", vec, {b, 2'b10});
    tick(); quiet();
    ef = 3'b010;
    see_stat("R4 acked, R5 eoi ignored");
    // R5 EOI with colliding requests
    req = 2'b11; addr = a_eoi(map_sel); wr = 1;
    tick(); quiet();
    ef = 3'b001;
    see_stat("R5 eoi done, R8 ch held");
    // R2 new request from done from the other channel
    req = ech ? 2'b01 : 2'b10; tick(); quiet();
    ef = 3'b100; ech = ~ech;
    see_stat("R2 accept from done clears eoi");
    grant = 1; tick(); quiet(); ef = 3'b110; see_stat("R3 second assert");
    iack = 1; tick(); quiet(); ef = 3'b010; see_stat("R4 second ack");
    addr = a_eoi(map_sel); wr = 1; tick(); quiet(); ef = 3'b001;
    see_stat("R5 second done");
  endtask

  initial begin
    logic [5:0] bases [4];
    logic [5:0] last_b;
    bases[0] = 6'h00; bases[1] = 6'h15; bases[2] = 6'h2A; bases[3] = 6'h3F;
    ef = 3'b000; ech = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    see_stat("R1 reset status");
    addr = a_vb(0); #1;
    chk("R1 reset base", rd_data, 8'h00);
    chk("R1 reset vec", vec, 8'h00);
    last_b = 0;
    for (int m = 0; m < 2; m++) begin
      map_sel = m[0];
      for (int p = 1; p < 4; p++) begin
        for (int k = 0; k < 4; k++) begin
          run_pass(p[1:0], bases[k]);
          last_b = bases[k];
        end
      end
    end
    // R7 and R6 full address sweep in both maps
    for (int m = 0; m < 2; m++) begin
      map_sel = m[0];
      for (int a = 0; a < 256; a++) begin
        logic [7:0] e;
        addr = a[7:0]; #1;
        if (a[7:0] == a_stat(m[0]))    e = exp_stat();
        else if (a[7:0] == a_vb(m[0])) e = {last_b, 2'b00};
        else                           e = 8'h00;
        chk("R7 R6 address map", rd_data, e);
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule